// File: doc/BRIEF.md
# Paged Address Translator with Associative Cache

This block turns a logical address into a physical address by paging. The upper bits of the logical address select a page and the lower bits are an offset inside it. A small fully associative translation cache is searched first. When it holds the page, the answer comes back one cycle after the request. When it does not, the block stalls its request port for one cycle, reads a direct-indexed page table, answers from that table and installs the translation in the cache.

Every page table entry carries a frame number and a read-only flag. A write to a read-only page is answered with a fault and a zeroed physical address. A configuration port loads page table entries and flushes the cache. Loading an entry also drops any cached copy of that page. Two free-running counters give the number of lookups and the number of cache hits, so software can work out the hit ratio.

Top module: `paging_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, both counters are 0, the cache holds no entry (the first lookup misses), and every page table entry maps to frame 0 as read-write.
- R2: The page number is req_addr[15:11] and the offset is req_addr[10:0]. A translation that does not fault returns rsp_paddr = {frame, offset}, with the offset unchanged.
- R3: A cycle with cfg_wr_en high stores cfg_frame and cfg_ro in the page table slot indexed by cfg_page. cfg_ro=1 marks the page read-only and cfg_ro=0 marks it read-write.
- R4: A request that hits in the cache is answered with rsp_valid=1 and rsp_hit=1 in the cycle after it is accepted.
- R5: A request that misses is answered two cycles after acceptance with rsp_hit=0. req_ready is 0 in the cycle between acceptance and answer. The translation is then cached, so the same page hits on the next request.
- R6: A write (req_write=1) to a read-only page returns rsp_fault=1 and rsp_paddr=0. A read of that page, and any access to a read-write page, returns rsp_fault=0.
- R7: The cache has 4 slots. A new translation fills the lowest-numbered empty slot. When all slots are full, it replaces slots in rotation, starting at slot 0.
- R8: A cycle with cfg_flush high empties the cache, so later requests miss.
- R9: Loading a page table entry drops any cached copy of that page. The next request to that page misses and returns the new frame.
- R10: Two pages mapped to the same frame both translate to that frame. Neither disturbs the other.
- R11: lookup_count rises by one for each accepted request, and hit_count rises by one for each request answered with rsp_hit=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Logical address |
| req_write | input | 1 | 1 for write access, 0 for read |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Write to a read-only page |
| rsp_hit | output | 1 | Answered from the translation cache |
| cfg_wr_en | input | 1 | Load one page table entry |
| cfg_page | input | 5 | Page table slot to load |
| cfg_frame | input | 5 | Frame number to store |
| cfg_ro | input | 1 | Read-only flag to store |
| cfg_flush | input | 1 | Empty the translation cache |
| lookup_count | output | 16 | Accepted requests since reset |
| hit_count | output | 16 | Cache hits since reset |

## Verification
A wrong cache state shows at the ports on the very next request to the affected page. A stale or missing slot changes rsp_hit and the response latency. A stale frame or protection flag changes rsp_paddr or rsp_fault in that same response. A wrong rotation pointer shows only later, when a page evicted out of order misses or hits against expectation. The bench therefore runs fill-and-evict sequences whose hit pattern differs for each slot choice.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int DEF_ADDR_W  = 16;
    localparam int DEF_PAGE_W  = 5;
    localparam int DEF_FRAME_W = 5;
    localparam int DEF_SLOTS   = 4;
    localparam int DEF_CNT_W   = 16;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_WALK = 1'b1
    } xlate_state_e;

    // next slot index in rotation, wrapping at slot count
    function automatic int unsigned next_slot(input int unsigned cur, input int unsigned slots);
        return (cur + 1 >= slots) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/pt_page_table.sv
module pt_page_table #(
    parameter int PAGE_W  = 5,
    parameter int FRAME_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_page,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_ro,
    input  logic [PAGE_W-1:0]  rd_page,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_ro
);
    localparam int PAGES = 1 << PAGE_W;

    logic [FRAME_W-1:0] frame_q [PAGES];
    logic [PAGES-1:0]   ro_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAGES; i++) frame_q[i] <= '0;
            ro_q <= '0;
        end else if (wr_en) begin
            frame_q[wr_page] <= wr_frame;
            ro_q[wr_page]    <= wr_ro;
        end
    end

    assign rd_frame = frame_q[rd_page];
    assign rd_ro    = ro_q[rd_page];
endmodule

// File: rtl/pt_tlb.sv
module pt_tlb #(
    parameter int SLOTS   = 4,
    parameter int PAGE_W  = 5,
    parameter int FRAME_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PAGE_W-1:0]  lk_page,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    output logic               lk_ro,
    input  logic               ins_en,
    input  logic [PAGE_W-1:0]  ins_page,
    input  logic [FRAME_W-1:0] ins_frame,
    input  logic               ins_ro,
    input  logic               inv_en,
    input  logic [PAGE_W-1:0]  inv_page,
    input  logic               flush
);
    import pt_pkg::*;
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SLOTS-1:0]   vld_q;
    logic [PAGE_W-1:0]  key_q [SLOTS];
    logic [FRAME_W-1:0] frm_q [SLOTS];
    logic [SLOTS-1:0]   ro_q;
    logic [IDX_W-1:0]   rr_q;
    logic [SLOTS-1:0]   match;
    logic [IDX_W-1:0]   victim;
    logic               has_free;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (key_q[g] == lk_page);
    end

    always_comb begin
        lk_frame = '0;
        lk_ro    = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            lk_frame = lk_frame | ({FRAME_W{match[i]}} & frm_q[i]);
            lk_ro    = lk_ro | (match[i] & ro_q[i]);
        end
    end
    assign lk_hit = |match;

    // lowest empty slot wins, else rotation pointer
    always_comb begin
        victim   = rr_q;
        has_free = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                victim   = IDX_W'(i);
                has_free = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            ro_q  <= '0;
            rr_q  <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                key_q[i] <= '0;
                frm_q[i] <= '0;
            end
        end else if (flush) begin
            vld_q <= '0;
        end else begin
            if (inv_en) begin
                for (int i = 0; i < SLOTS; i++)
                    if (key_q[i] == inv_page) vld_q[i] <= 1'b0;
            end
            if (ins_en) begin
                vld_q[victim] <= 1'b1;
                key_q[victim] <= ins_page;
                frm_q[victim] <= ins_frame;
                ro_q[victim]  <= ins_ro;
                if (!has_free) rr_q <= IDX_W'(next_slot(int'(rr_q), SLOTS));
            end
        end
    end

    // R4: a page never sits in two slots
    a_r4_single_match: assert property (@(posedge clk) disable iff (rst) $onehot0(match));
    // R8: flush leaves no slot valid
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst) flush |=> (vld_q == '0));
    // R7: rotation pointer holds while an empty slot is filled
    a_r7_rr_holds_on_fill: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !flush && !(&vld_q)) |=> $stable(rr_q));
endmodule

// File: rtl/paging_xlate.sv
module paging_xlate #(
    parameter int ADDR_W  = pt_pkg::DEF_ADDR_W,
    parameter int PAGE_W  = pt_pkg::DEF_PAGE_W,
    parameter int FRAME_W = pt_pkg::DEF_FRAME_W,
    parameter int SLOTS   = pt_pkg::DEF_SLOTS,
    parameter int CNT_W   = pt_pkg::DEF_CNT_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_write,
    output logic                        req_ready,
    output logic                        rsp_valid,
    output logic [FRAME_W+ADDR_W-PAGE_W-1:0] rsp_paddr,
    output logic                        rsp_fault,
    output logic                        rsp_hit,
    input  logic                        cfg_wr_en,
    input  logic [PAGE_W-1:0]           cfg_page,
    input  logic [FRAME_W-1:0]          cfg_frame,
    input  logic                        cfg_ro,
    input  logic                        cfg_flush,
    output logic [CNT_W-1:0]            lookup_count,
    output logic [CNT_W-1:0]            hit_count
);
    import pt_pkg::*;
    localparam int OFF_W   = ADDR_W - PAGE_W;
    localparam int PADDR_W = FRAME_W + OFF_W;

    xlate_state_e       state_q;
    logic [PAGE_W-1:0]  page_q;
    logic [OFF_W-1:0]   off_q;
    logic               wr_q;
    logic [PAGE_W-1:0]  req_page;
    logic               accept;
    logic               tlb_hit, tlb_ro, pt_ro, ins_en;
    logic [FRAME_W-1:0] tlb_frame, pt_frame;

    assign req_page  = req_addr[ADDR_W-1:OFF_W];
    assign req_ready = (state_q == XS_IDLE);
    assign accept    = req_valid && req_ready;
    // skip install when the same cycle flushes or reloads this page
    assign ins_en    = (state_q == XS_WALK) && !cfg_flush && !(cfg_wr_en && cfg_page == page_q);

    pt_page_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(cfg_wr_en), .wr_page(cfg_page), .wr_frame(cfg_frame), .wr_ro(cfg_ro),
        .rd_page(page_q), .rd_frame(pt_frame), .rd_ro(pt_ro)
    );

    pt_tlb #(.SLOTS(SLOTS), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_tlb (
        .clk(clk), .rst(rst),
        .lk_page(req_page), .lk_hit(tlb_hit), .lk_frame(tlb_frame), .lk_ro(tlb_ro),
        .ins_en(ins_en), .ins_page(page_q), .ins_frame(pt_frame), .ins_ro(pt_ro),
        .inv_en(cfg_wr_en), .inv_page(cfg_page), .flush(cfg_flush)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= XS_IDLE;
            page_q       <= '0;
            off_q        <= '0;
            wr_q         <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_paddr    <= '0;
            rsp_fault    <= 1'b0;
            rsp_hit      <= 1'b0;
            lookup_count <= '0;
            hit_count    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                XS_IDLE: if (accept) begin
                    lookup_count <= lookup_count + 1'b1;
                    page_q <= req_page;
                    off_q  <= req_addr[OFF_W-1:0];
                    wr_q   <= req_write;
                    if (tlb_hit) begin
                        hit_count <= hit_count + 1'b1;
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_fault <= req_write && tlb_ro;
                        rsp_paddr <= (req_write && tlb_ro) ? '0
                                     : {tlb_frame, req_addr[OFF_W-1:0]};
                    end else begin
                        state_q <= XS_WALK;
                    end
                end
                XS_WALK: begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b0;
                    rsp_fault <= wr_q && pt_ro;
                    rsp_paddr <= (wr_q && pt_ro) ? '0 : {pt_frame, off_q};
                    state_q   <= XS_IDLE;
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    // R4: cache hit answered on the next cycle
    a_r4_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (accept && tlb_hit) |=> (rsp_valid && rsp_hit));
    // R5: a miss stalls the request port for one cycle
    a_r5_miss_stalls: assert property (@(posedge clk) disable iff (rst)
        (accept && !tlb_hit) |=> !req_ready);
    // R5: the walk cycle ends with a non-hit response
    a_r5_walk_answers: assert property (@(posedge clk) disable iff (rst)
        (state_q == XS_WALK) |=> (rsp_valid && !rsp_hit && req_ready));
    // R6: a fault carries no address
    a_r6_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
    // R11: hit counter advances only with a hit response
    a_r11_hit_count_step: assert property (@(posedge clk) disable iff (rst)
        (hit_count != $past(hit_count)) |-> (rsp_valid && rsp_hit));
endmodule

// File: tb/tb_paging_xlate.sv
module tb_paging_xlate;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_ready;
    logic [15:0] req_addr;
    logic        rsp_valid, rsp_fault, rsp_hit;
    logic [15:0] rsp_paddr;
    logic        cfg_wr_en, cfg_ro, cfg_flush;
    logic [4:0]  cfg_page, cfg_frame;
    logic [15:0] lookup_count, hit_count;

    int n_checks = 0, n_fail = 0, n_look = 0, n_hit = 0;
    logic [4:0] m_frame [32];
    logic       m_ro    [32];

    always #5 clk = ~clk;

    paging_xlate dut (.*);

    // {write, page, offset}, expected hit
    localparam int NV = 12;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 5'd1, 11'h02A}, {1'b1, 5'd1, 11'h7FF}, {1'b0, 5'd2, 11'h000},
        {1'b1, 5'd3, 11'h155}, {1'b0, 5'd3, 11'h155}, {1'b0, 5'd4, 11'h3C3},
        {1'b0, 5'd2, 11'h001}, {1'b0, 5'd5, 11'h640}, {1'b0, 5'd1, 11'h111},
        {1'b0, 5'd2, 11'h222}, {1'b1, 5'd4, 11'h333}, {1'b0, 5'd5, 11'h444}};
    localparam logic EXPH [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
                                   1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] pg, input logic [4:0] fr, input logic ro);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_page = pg; cfg_frame = fr; cfg_ro = ro;
        m_frame[pg] = fr; m_ro[pg] = ro;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic lookup(input logic wr, input logic [15:0] addr, input logic exp_hit, input string tag);
        logic [4:0]  pg;
        logic        efault;
        logic [15:0] epaddr;
        int          lat;
        pg = addr[15:11];
        efault = wr && m_ro[pg];
        epaddr = efault ? 16'h0 : {m_frame[pg], addr[10:0]};
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (!exp_hit) check(!req_ready, {tag, " R5 stall"}, 32'(req_ready), 32'd0);
        while (!rsp_valid && lat < 10) begin @(negedge clk); lat++; end
        n_look++;
        if (exp_hit) n_hit++;
        check(lat == (exp_hit ? 1 : 2), {tag, " R4/R5 latency"}, 32'(lat), exp_hit ? 32'd1 : 32'd2);
        check(rsp_hit == exp_hit, {tag, " R4/R5 hit"}, 32'(rsp_hit), 32'(exp_hit));
        check(rsp_fault == efault, {tag, " R6 fault"}, 32'(rsp_fault), 32'(efault));
        check(rsp_paddr == epaddr, {tag, " R2 paddr"}, 32'(rsp_paddr), 32'(epaddr));
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_frame[i] = '0; m_ro[i] = 1'b0; end
        rst = 1'b1; req_valid = 0; req_write = 0; req_addr = '0;
        cfg_wr_en = 0; cfg_ro = 0; cfg_flush = 0; cfg_page = '0; cfg_frame = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(req_ready && !rsp_valid, "R1 ready/valid", {req_ready, rsp_valid}, 32'h2);
        check(lookup_count == 0 && hit_count == 0, "R1 counters", {lookup_count, hit_count}, 0);
        lookup(1'b1, {5'd9, 11'h5A5}, 1'b0, "R1 empty cache, frame 0 rw");

        // R3: load table, page p -> frame (7p+3) mod 32, pages with p%4==3 read-only
        for (int p = 0; p < 32; p++) cfg_write(5'(p), 5'((p * 7 + 3) % 32), (p % 4) == 3);

        // R7: fill and rotate through vector table
        for (int v = 0; v < NV; v++)
            lookup(VEC[v][16], VEC[v][15:0], EXPH[v], $sformatf("R7 vec%0d", v));

        // R8: flush empties the cache
        @(negedge clk); cfg_flush = 1'b1;
        @(negedge clk); cfg_flush = 1'b0;
        lookup(1'b0, {5'd4, 11'h010}, 1'b0, "R8 after flush");
        lookup(1'b0, {5'd4, 11'h011}, 1'b1, "R5 refill hits");

        // R9: reload drops the cached copy
        cfg_write(5'd4, 5'd30, 1'b1);
        lookup(1'b1, {5'd4, 11'h012}, 1'b0, "R9 reload miss");
        lookup(1'b0, {5'd4, 11'h013}, 1'b1, "R9 new frame hit");

        // R10: shared frame
        cfg_write(5'd6, 5'd20, 1'b0);
        cfg_write(5'd10, 5'd20, 1'b0);
        lookup(1'b1, {5'd6, 11'h0AB}, 1'b0, "R10 page6");
        lookup(1'b0, {5'd10, 11'h0CD}, 1'b0, "R10 page10");
        lookup(1'b1, {5'd6, 11'h0EF}, 1'b1, "R10 page6 again");
        lookup(1'b0, {5'd10, 11'h7FE}, 1'b1, "R10 page10 again");

        // R11: counters
        @(negedge clk);
        check(lookup_count == 16'(n_look), "R11 lookup_count", 32'(lookup_count), 32'(n_look));
        check(hit_count == 16'(n_hit), "R11 hit_count", 32'(hit_count), 32'(n_hit));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule